// File: doc/BRIEF.md
# Unconditional Jump Target Calculator

This block works out where execution continues after an unconditional jump. A decoder that has already recognised the opcode presents the current instruction pointer, the current code segment, a code for the jump form, and the bytes that follow the opcode. One clock later the block returns four results: the new instruction pointer, the code segment to use, a flag that says whether the segment is reloaded, and the total instruction length in bytes.

Three forms are supported. The two relative forms, short and near, add a signed displacement to the address of the next instruction. The short form carries one displacement byte, so it reaches -128 to +127 bytes from that address. The near form carries a two-byte displacement and reaches about 32K bytes either way. The far form carries no displacement. It loads an absolute offset and a new segment value, each held in two bytes with the low byte first. Only the bytes that a form uses take part in the result.

Top module: `jump_target_calc`

## Requirements
- R1: While rst_ni is low, and until the first accepted request, rsp_valid_o, cs_load_o, len_o, next_ip_o and next_cs_o are all zero.
- R2: A request with req_valid_i high and a form code of 0, 1 or 2 is captured at a rising edge. Its results, with rsp_valid_o high, appear after that edge and stay until the next edge. rsp_valid_o is high only in the cycle after an accepted request.
- R3: Form code 0 (short) gives len_o = 2 and next_ip_o = ip_i + 2 + the sign-extended value of opnd_i[7:0]. It also gives next_cs_o = cs_i and cs_load_o = 0.
- R4: Form code 1 (near) gives len_o = 3 and next_ip_o = ip_i + 3 + the signed 16-bit value {opnd_i[15:8], opnd_i[7:0]}. It also gives next_cs_o = cs_i and cs_load_o = 0.
- R5: Form code 2 (far) gives len_o = 5, next_ip_o = {opnd_i[15:8], opnd_i[7:0]}, next_cs_o = {opnd_i[31:24], opnd_i[23:16]} and cs_load_o = 1.
- R6: The relative sums are taken modulo 2^16. A target below address 0 or above 0xFFFF wraps around without any error indication.
- R7: Form code 3 is reserved. A request that carries it gives rsp_valid_o = 0 in the next cycle and leaves next_ip_o, next_cs_o, cs_load_o and len_o unchanged.
- R8: When req_valid_i is low, the next cycle has rsp_valid_o = 0 and all result outputs keep their previous values.
- R9: Operand bytes beyond a form's length have no effect on the result. For the short form these are opnd_i[31:8]. For the near form they are opnd_i[31:16].
- R10: Requests on consecutive cycles are each answered in the cycle after their own capture. A result is never merged with the result of a neighbouring request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request present this cycle |
| form_i | input | 2 | Jump form: 0 short, 1 near, 2 far, 3 reserved |
| ip_i | input | 16 | Offset of the jump's first byte |
| cs_i | input | 16 | Current code segment |
| opnd_i | input | 32 | Bytes following the opcode, the first byte in [7:0] |
| rsp_valid_o | output | 1 | Results are valid this cycle |
| next_ip_o | output | 16 | Target offset |
| next_cs_o | output | 16 | Segment to continue in |
| cs_load_o | output | 1 | Segment is reloaded |
| len_o | output | 3 | Instruction length in bytes |

## Verification
Sign extension of the displacement and the 16-bit wraparound act in the same addition. The bench drives short and near jumps whose IP lies close to 0x0000 or 0xFFFF, with displacements on both sides of zero. It compares each target against a sum that the bench works out at full width and reduces to 16 bits itself. Back-to-back requests are issued on consecutive edges. The bench then checks that the first result is visible for exactly one cycle and is replaced cleanly by the second, without mixing the two.

// File: rtl/jump_target_pkg.sv
package jump_target_pkg;
  parameter int unsigned BYTE_W     = 8;
  parameter int unsigned OPND_BYTES = 4;
  parameter int unsigned OFF_W      = 2 * BYTE_W;
  parameter int unsigned OPND_W     = OPND_BYTES * BYTE_W;
  parameter int unsigned LEN_W      = 3;

  typedef enum logic [1:0] {
    JF_SHORT = 2'd0,
    JF_NEAR  = 2'd1,
    JF_FAR   = 2'd2,
    JF_RSVD  = 2'd3
  } jump_form_e;

  localparam logic [LEN_W-1:0] LEN_SHORT = LEN_W'(2);
  localparam logic [LEN_W-1:0] LEN_NEAR  = LEN_W'(3);
  localparam logic [LEN_W-1:0] LEN_FAR   = LEN_W'(5);

  typedef struct packed {
    logic [OFF_W-1:0] ip;
    logic [OFF_W-1:0] cs;
    logic             cs_load;
    logic [LEN_W-1:0] len;
  } jump_result_t;
endpackage

// File: rtl/jt_operand_unpack.sv
module jt_operand_unpack
  import jump_target_pkg::*;
(
  input  jump_form_e        form_i,
  input  logic [OPND_W-1:0] opnd_i,
  output logic              legal_o,
  output logic              relative_o,
  output logic [OFF_W-1:0]  disp_o,
  output logic [OFF_W-1:0]  far_off_o,
  output logic [OFF_W-1:0]  far_seg_o,
  output logic [LEN_W-1:0]  len_o
);
  localparam int unsigned EXT_W = OFF_W - BYTE_W;

  logic [BYTE_W-1:0] byte_q [OPND_BYTES];

  for (genvar k = 0; k < OPND_BYTES; k++) begin : g_split
    assign byte_q[k] = opnd_i[k*BYTE_W +: BYTE_W];
  end

  assign far_off_o = {byte_q[1], byte_q[0]};
  assign far_seg_o = {byte_q[3], byte_q[2]};

  always_comb begin
    legal_o    = 1'b1;
    relative_o = 1'b1;
    disp_o     = '0;
    len_o      = '0;
    unique case (form_i)
      JF_SHORT: begin
        disp_o = {{EXT_W{byte_q[0][BYTE_W-1]}}, byte_q[0]};
        len_o  = LEN_SHORT;
      end
      JF_NEAR: begin
        disp_o = {byte_q[1], byte_q[0]};
        len_o  = LEN_NEAR;
      end
      JF_FAR: begin
        relative_o = 1'b0;
        len_o      = LEN_FAR;
      end
      default: begin
        legal_o    = 1'b0;
        relative_o = 1'b0;
      end
    endcase
  end

  always_comb begin
    if (form_i == JF_SHORT) begin
      assert (disp_o[OFF_W-1:BYTE_W] == {EXT_W{opnd_i[BYTE_W-1]}})
        else $error("p_short_sext_r3");
    end
  end
endmodule

// File: rtl/jt_rel_adder.sv
module jt_rel_adder
  import jump_target_pkg::*;
(
  input  logic [OFF_W-1:0] ip_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic [OFF_W-1:0] disp_i,
  output logic [OFF_W-1:0] target_o
);
  logic [OFF_W-1:0] next_seq;

  // address of the following instruction, then the displacement, both modulo 2^OFF_W
  assign next_seq = ip_i + OFF_W'(len_i);
  assign target_o = next_seq + disp_i;
endmodule

// File: rtl/jt_result_reg.sv
module jt_result_reg
  import jump_target_pkg::*;
(
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  jump_result_t res_i,
  output logic         valid_o,
  output jump_result_t res_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      res_o   <= '0;
    end else begin
      valid_o <= load_i;
      if (load_i) res_o <= res_i;
    end
  end

  p_valid_follows_load_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> valid_o);
  p_hold_without_load_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> !valid_o && $stable(res_o));
endmodule

// File: rtl/jump_target_calc.sv
module jump_target_calc
  import jump_target_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic [1:0]        form_i,
  input  logic [OFF_W-1:0]  ip_i,
  input  logic [OFF_W-1:0]  cs_i,
  input  logic [OPND_W-1:0] opnd_i,
  output logic              rsp_valid_o,
  output logic [OFF_W-1:0]  next_ip_o,
  output logic [OFF_W-1:0]  next_cs_o,
  output logic              cs_load_o,
  output logic [LEN_W-1:0]  len_o
);
  jump_form_e       form;
  logic             legal, relative;
  logic [OFF_W-1:0] disp, far_off, far_seg, rel_target;
  logic [LEN_W-1:0] len;
  jump_result_t     res_d, res_q;

  assign form = jump_form_e'(form_i);

  jt_operand_unpack i_unpack (
    .form_i     (form),
    .opnd_i     (opnd_i),
    .legal_o    (legal),
    .relative_o (relative),
    .disp_o     (disp),
    .far_off_o  (far_off),
    .far_seg_o  (far_seg),
    .len_o      (len)
  );

  jt_rel_adder i_adder (
    .ip_i     (ip_i),
    .len_i    (len),
    .disp_i   (disp),
    .target_o (rel_target)
  );

  always_comb begin
    res_d.ip      = relative ? rel_target : far_off;
    res_d.cs      = relative ? cs_i : far_seg;
    res_d.cs_load = !relative;
    res_d.len     = len;
  end

  jt_result_reg i_res (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (req_valid_i && legal),
    .res_i   (res_d),
    .valid_o (rsp_valid_o),
    .res_o   (res_q)
  );

  assign next_ip_o = res_q.ip;
  assign next_cs_o = res_q.cs;
  assign cs_load_o = res_q.cs_load;
  assign len_o     = res_q.len;

  p_rel_keeps_cs_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && (form_i == 2'd0 || form_i == 2'd1)
      |=> !cs_load_o && next_cs_o == $past(cs_i));
  p_near_len_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && form_i == 2'd1 |=> len_o == 3'd3);
  p_far_load_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && form_i == 2'd2
      |=> cs_load_o && len_o == 3'd5
          && next_ip_o == $past(opnd_i[15:0]) && next_cs_o == $past(opnd_i[31:16]));
  p_reserved_ignored_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && form_i == 2'd3
      |=> !rsp_valid_o && $stable(next_ip_o) && $stable(next_cs_o)
          && $stable(cs_load_o) && $stable(len_o));
endmodule

// File: tb/test_jump_target_calc.sv
module test_jump_target_calc;
  localparam time CLK_PERIOD = 10ns;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_valid_i = 1'b0;
  logic [1:0]  form_i = '0;
  logic [15:0] ip_i = '0, cs_i = '0;
  logic [31:0] opnd_i = '0;
  logic        rsp_valid_o, cs_load_o;
  logic [15:0] next_ip_o, next_cs_o;
  logic [2:0]  len_o;

  int n_cmp = 0, n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  jump_target_calc i_jump_target_calc (
    .clk_i(clk), .rst_ni(rst_ni), .req_valid_i(req_valid_i), .form_i(form_i),
    .ip_i(ip_i), .cs_i(cs_i), .opnd_i(opnd_i), .rsp_valid_o(rsp_valid_o),
    .next_ip_o(next_ip_o), .next_cs_o(next_cs_o), .cs_load_o(cs_load_o), .len_o(len_o)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] rel_exp(input logic [15:0] ip, input int len, input int disp);
    int full;
    full = int'(ip) + len + disp;
    return full[15:0];
  endfunction

  // one request, then check the response after the capturing edge
  task automatic issue(input logic [1:0] f, input logic [15:0] ip, input logic [15:0] cs,
                       input logic [31:0] op);
    @(negedge clk);
    req_valid_i = 1'b1; form_i = f; ip_i = ip; cs_i = cs; opnd_i = op;
    @(negedge clk);
    req_valid_i = 1'b0;
  endtask

  task automatic expect_rel(input string tag, input int len, input logic [15:0] ip_exp,
                            input logic [15:0] cs_exp);
    check({tag, " valid"}, 32'(rsp_valid_o), 32'd1);
    check({tag, " ip"}, 32'(next_ip_o), 32'(ip_exp));
    check({tag, " cs"}, 32'(next_cs_o), 32'(cs_exp));
    check({tag, " cs_load"}, 32'(cs_load_o), 32'd0);
    check({tag, " len"}, 32'(len_o), 32'(len));
  endtask

  task automatic t_reset;
    check("R1 valid", 32'(rsp_valid_o), 0);
    check("R1 ip", 32'(next_ip_o), 0);
    check("R1 cs", 32'(next_cs_o), 0);
    check("R1 cs_load", 32'(cs_load_o), 0);
    check("R1 len", 32'(len_o), 0);
  endtask

  task automatic t_short;
    issue(2'd0, 16'h1000, 16'h2222, 32'h0000_0010);
    expect_rel("R3 fwd", 2, rel_exp(16'h1000, 2, 16), 16'h2222);
    issue(2'd0, 16'h1000, 16'h2222, 32'h0000_0080);
    expect_rel("R3 min", 2, rel_exp(16'h1000, 2, -128), 16'h2222);
    issue(2'd0, 16'h1000, 16'h3333, 32'h0000_007F);
    expect_rel("R3 max", 2, rel_exp(16'h1000, 2, 127), 16'h3333);
    issue(2'd0, 16'h1000, 16'h3333, 32'h0000_00FE);
    expect_rel("R3 self", 2, 16'h1000, 16'h3333);
  endtask

  task automatic t_near;
    issue(2'd1, 16'h4000, 16'h0101, 32'h0000_1234);
    expect_rel("R4 fwd", 3, 16'h5237, 16'h0101);
    issue(2'd1, 16'h4000, 16'h0101, 32'h0000_8000);
    expect_rel("R4 back", 3, rel_exp(16'h4000, 3, -32768), 16'h0101);
  endtask

  task automatic t_wrap;
    issue(2'd0, 16'hFFFF, 16'h0001, 32'h0000_0001);
    expect_rel("R6 short up", 2, 16'h0002, 16'h0001);
    issue(2'd0, 16'h0000, 16'h0001, 32'h0000_0080);
    expect_rel("R6 short down", 2, 16'hFF82, 16'h0001);
    issue(2'd1, 16'hFFF0, 16'h0001, 32'h0000_0020);
    expect_rel("R6 near up", 3, 16'h0013, 16'h0001);
  endtask

  task automatic t_unused_bytes;
    issue(2'd0, 16'h0200, 16'h0505, 32'hDEAD_BE05);
    expect_rel("R9 short", 2, 16'h0207, 16'h0505);
    issue(2'd1, 16'h0200, 16'h0505, 32'hFFFF_0010);
    expect_rel("R9 near", 3, 16'h0213, 16'h0505);
  endtask

  task automatic t_far;
    issue(2'd2, 16'h7777, 16'h1111, 32'hABCD_1234);
    check("R5 valid", 32'(rsp_valid_o), 1);
    check("R5 ip", 32'(next_ip_o), 32'h1234);
    check("R5 cs", 32'(next_cs_o), 32'hABCD);
    check("R5 cs_load", 32'(cs_load_o), 1);
    check("R5 len", 32'(len_o), 5);
  endtask

  task automatic t_reserved;
    issue(2'd3, 16'h9999, 16'h8888, 32'h5555_5555);
    check("R7 valid", 32'(rsp_valid_o), 0);
    check("R7 ip", 32'(next_ip_o), 32'h1234);
    check("R7 cs", 32'(next_cs_o), 32'hABCD);
    check("R7 cs_load", 32'(cs_load_o), 1);
    check("R7 len", 32'(len_o), 5);
  endtask

  task automatic t_idle;
    ip_i = 16'hAAAA; cs_i = 16'hBBBB; opnd_i = 32'hCCCC_DDDD; form_i = 2'd0;
    repeat (3) @(negedge clk);
    check("R8 valid", 32'(rsp_valid_o), 0);
    check("R8 ip", 32'(next_ip_o), 32'h1234);
    check("R8 cs", 32'(next_cs_o), 32'hABCD);
  endtask

  task automatic t_back_to_back;
    @(negedge clk);
    req_valid_i = 1'b1; form_i = 2'd1; ip_i = 16'h0100; cs_i = 16'h0042; opnd_i = 32'h0000_0100;
    @(negedge clk);
    form_i = 2'd2; ip_i = 16'h0000; cs_i = 16'h0000; opnd_i = 32'h6000_0300;
    expect_rel("R10 first", 3, 16'h0203, 16'h0042);
    @(negedge clk);
    req_valid_i = 1'b0;
    check("R10 second valid", 32'(rsp_valid_o), 1);
    check("R10 second ip", 32'(next_ip_o), 32'h0300);
    check("R10 second cs", 32'(next_cs_o), 32'h6000);
    check("R10 second cs_load", 32'(cs_load_o), 1);
    @(negedge clk);
    check("R2 single pulse", 32'(rsp_valid_o), 0);
  endtask

  initial begin
    #(CLK_PERIOD * 2);
    t_reset();
    @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    t_reset();
    t_short();
    t_near();
    t_wrap();
    t_unused_bytes();
    t_far();
    t_reserved();
    t_idle();
    t_back_to_back();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule